// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the management-port master of an Ethernet MAC. It runs clause-22 read and write transactions to an external PHY. Software starts a transaction with one 32-bit store to the command register. That word already holds every field of the frame. The block sends a preamble, then shifts the word out on MDIO against a divided clock on MDC. For a read, it gives up the line for the turnaround and captures the PHY's 16 data bits.

When the last bit has been clocked, a sticky completion event is raised, and software clears it by writing a 1 to it. Software polls the event; there is no busy flag. After a read, the value from the PHY sits in the low half of the command register. One speed register sets the MDC rate, and a value of zero stops MDC altogether.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every register address (0 command/data, 1 event, 2 speed, 3 unused) reads zero, MDC is low and MDIO is released (`mdio_oe` low, `mdio_o` low).
- R2: A frame on the wire is 32 ones followed by command bits 31 down to 0. The command fields are:
  - bits 31:30: start
  - bits 29:28: opcode, where 10 is a read and any other value is sent as a write
  - bits 27:23: PHY address
  - bits 22:18: register address
  - bits 17:16: turnaround
  - bits 15:0: data

  Each bit is presented while MDC is low and held steady while MDC is high. A write frame drives all 64 bits.
- R3: With a nonzero speed value S (address 2, low 8 bits), MDC spends S system clocks high and S low. A frame has exactly 64 MDC pulses. The completion event becomes visible 128·S clocks after the clock edge that accepted the command. MDC rests low between frames.
- R4: With speed value zero, MDC does not toggle and a started frame makes no progress. Once a nonzero value is written, the frame resumes and completes normally.
- R5: Completion sets bit 23 of address 1 at the falling MDC edge that ends the last bit. The bit stays set until software clears it.
- R6: Writing address 1 with bit 23 set clears the event. A write with bit 23 clear leaves it set.
- R7: In a read frame, MDIO is released from the first turnaround bit (frame bit 46) to the end of the frame. The block samples 16 bits, MSB first, on rising MDC edges. These bits replace bits 15:0 of the command register, and bits 31:16 are kept.
- R8: A write to the command register while a frame is in progress is ignored. It changes neither the frame on the wire nor the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A bit counter that slips shows up at the ports within one frame, in two ways:
- the PHY model counts a number of MDC pulses other than 64;
- the completion event appears a multiple of 2·S clocks away from 128·S.

A wrong phase decode changes the `mdio_oe` pattern at frame bit 46. A skewed sample point shifts the value read back in the command register. Both are caught when that frame completes.

A command register that is not frozen during a frame alters the remaining wire bits immediately, and it alters the readback after completion.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_LEN    = 32;
    localparam int CMD_LEN    = 32;
    localparam int DATA_LEN   = 16;
    localparam int FRAME_LEN  = PRE_LEN + CMD_LEN;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int CMD_IDX_W  = $clog2(CMD_LEN);
    // first frame bit the PHY owns on a read (turnaround), and first data bit
    localparam int TURN_POS   = PRE_LEN + 14;
    localparam int RDATA_POS  = FRAME_LEN - DATA_LEN;
    localparam int EVT_DONE_BIT = 23;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic [1:0]          st;
        logic [1:0]          op;
        logic [4:0]          phy;
        logic [4:0]          regad;
        logic [1:0]          ta;
        logic [DATA_LEN-1:0] data;
    } mgmt_cmd_t;

    typedef enum logic [1:0] {
        RA_CMD  = 2'd0,
        RA_EVT  = 2'd1,
        RA_SPD  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PH_PRE,
        PH_HEAD,
        PH_TURN,
        PH_DATA
    } frame_phase_e;

    function automatic frame_phase_e phase_at(logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(PRE_LEN))   return PH_PRE;
        if (idx < IDX_W'(TURN_POS))  return PH_HEAD;
        if (idx < IDX_W'(RDATA_POS)) return PH_TURN;
        return PH_DATA;
    endfunction

    function automatic logic cmd_is_read(mgmt_cmd_t c);
        return c.op == OP_READ;
    endfunction

    // Preamble bits are ones; afterwards the command goes out MSB first.
    // PRE_LEN equals CMD_LEN, so the low index bits inverted give 31-k.
    function automatic logic wire_bit(mgmt_cmd_t c, logic [IDX_W-1:0] idx);
        logic [CMD_LEN-1:0] v;
        v = c;
        if (idx < IDX_W'(PRE_LEN)) return 1'b1;
        return v[~idx[CMD_IDX_W-1:0]];
    endfunction

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             mdc,
    output logic             rise_now,
    output logic             fall_now
);

    logic [DIV_W-1:0] cnt;
    logic             enabled;
    logic             wrap;

    assign enabled  = run && (half_period != '0);
    // >= keeps the divider from stalling if the speed shrinks mid-count
    assign wrap     = enabled && (cnt >= half_period - 1'b1);
    assign rise_now = wrap && !mdc;
    assign fall_now = wrap &&  mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (enabled) begin
            if (wrap) begin
                cnt <= '0;
                mdc <= ~mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: a zero speed value freezes MDC
    p_mdc_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (run && half_period == '0) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  mgmt_cmd_t           cmd,
    input  logic                rise_now,
    input  logic                fall_now,
    input  logic                mdio_i,
    output logic                busy,
    output logic                done,
    output logic [DATA_LEN-1:0] rd_word,
    output logic                mdio_o,
    output logic                mdio_oe
);

    logic [IDX_W-1:0] idx;
    frame_phase_e     phase;
    logic             is_rd;
    logic             last_bit;
    logic             drive;

    assign phase    = phase_at(idx);
    assign is_rd    = cmd_is_read(cmd);
    assign last_bit = (idx == IDX_W'(FRAME_LEN - 1));
    assign done     = busy && fall_now && last_bit;
    assign drive    = busy && !(is_rd && (phase == PH_TURN || phase == PH_DATA));
    assign mdio_oe  = drive;
    assign mdio_o   = drive && wire_bit(cmd, idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            rd_word <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else begin
            if (rise_now && is_rd && phase == PH_DATA)
                rd_word <= {rd_word[DATA_LEN-2:0], mdio_i};
            if (fall_now) begin
                if (last_bit) busy <= 1'b0;
                else          idx  <= idx + 1'b1;
            end
        end
    end

    // R7: once the line is released in a read, it stays released to the end
    p_stay_released_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && !mdio_oe && !done) |=> !mdio_oe);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic                busy,
    input  logic                done,
    input  logic [DATA_LEN-1:0] rd_word,
    output logic                start,
    output mgmt_cmd_t           cmd,
    output logic [DIV_W-1:0]    half_period,
    output logic                evt_done,
    output logic [31:0]         reg_rdata
);

    reg_addr_e sel;

    assign sel   = reg_addr_e'(reg_addr);
    assign start = reg_we && sel == RA_CMD && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd         <= '0;
            half_period <= '0;
            evt_done    <= 1'b0;
        end else begin
            if (start)
                cmd <= mgmt_cmd_t'(reg_wdata);
            else if (done && cmd_is_read(cmd))
                cmd.data <= rd_word;

            if (reg_we && sel == RA_SPD)
                half_period <= reg_wdata[DIV_W-1:0];

            if (done)
                evt_done <= 1'b1;
            else if (reg_we && sel == RA_EVT && reg_wdata[EVT_DONE_BIT])
                evt_done <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RA_CMD:  reg_rdata = cmd;
            RA_EVT:  reg_rdata[EVT_DONE_BIT] = evt_done;
            RA_SPD:  reg_rdata[DIV_W-1:0] = half_period;
            default: reg_rdata = '0;
        endcase
    end

    // R8: command register frozen for the whole frame
    p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd));

    // R5: the event only rises as a frame ends
    p_evt_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_done) |-> ($past(busy) && !busy));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    logic                start;
    logic                busy;
    logic                done;
    logic                evt_done;
    logic                rise_now;
    logic                fall_now;
    logic [DIV_W-1:0]    half_period;
    logic [DATA_LEN-1:0] rd_word;
    mgmt_cmd_t           cmd;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .busy        (busy),
        .done        (done),
        .rd_word     (rd_word),
        .start       (start),
        .cmd         (cmd),
        .half_period (half_period),
        .evt_done    (evt_done),
        .reg_rdata   (reg_rdata)
    );

    mdio_mdc_div #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .run         (busy),
        .half_period (half_period),
        .mdc         (mdc),
        .rise_now    (rise_now),
        .fall_now    (fall_now)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (cmd),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rd_word  (rd_word),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // R3: MDC rests low outside a frame
    p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R2: the wire holds still while MDC is high
    p_wire_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R6: a clear with no simultaneous completion leaves the event low
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd1 && reg_wdata[EVT_DONE_BIT] && !done) |=> !evt_done);

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int cyc = 0;
    int c0 = 0;
    int rcnt = 0;
    logic [63:0] got_o = '0;
    logic [63:0] got_oe = '0;
    logic [15:0] phy_mem [32];

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdio_i    (mdio_i),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // PHY model: capture the wire on rising MDC, answer reads on falling MDC
    always @(posedge mdc) begin
        if (rcnt < 64) begin
            got_o[6'(63 - rcnt)]  = mdio_o;
            got_oe[6'(63 - rcnt)] = mdio_oe;
        end
        rcnt++;
    end

    always @(negedge mdc) begin
        if (got_o[29:28] == 2'b10 && rcnt >= 48 && rcnt < 64)
            mdio_i = phy_mem[got_o[22:18]][4'(63 - rcnt)];
        else
            mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    task automatic begin_frame(input logic [31:0] c);
        got_o = '0;
        got_oe = '0;
        rcnt = 0;
        wr(2'd0, c);
        c0 = cyc;
    endtask

    // spd == 0 skips the duration check
    task automatic end_frame(input logic [31:0] c, input int spd, input string tag);
        bit found;
        bit rd;
        logic [63:0] exp_oe;
        logic [31:0] exp_rb;
        found = 1'b0;
        rd = (c[29:28] == 2'b10);
        reg_addr = 2'd1;
        while (!found && (cyc - c0) < 40000) begin
            @(negedge clk);
            if (reg_rdata[23]) found = 1'b1;
        end
        check({tag, " R5 event set"}, 64'(found), 64'd1);
        if (spd != 0)
            check({tag, " R3 frame duration"}, 64'(cyc - c0), 64'(128 * spd));
        check({tag, " R3 MDC pulse count"}, 64'(rcnt), 64'd64);
        exp_oe = rd ? ({64{1'b1}} << 18) : {64{1'b1}};
        check({tag, " R7 output enable pattern"}, got_oe, exp_oe);
        check({tag, " R2 wire bits"}, got_o, {32'hffff_ffff, c} & exp_oe);
        reg_addr = 2'd0;
        #1;
        exp_rb = rd ? {c[31:16], phy_mem[c[22:18]]} : c;
        check({tag, " R7 command readback"}, 64'(reg_rdata), 64'(exp_rb));
        if (!rd) phy_mem[c[22:18]] = c[15:0];
        check({tag, " R3 idle MDC and MDIO"}, {62'd0, mdc, mdio_oe}, 64'd0);
        wr(2'd1, 32'hff7f_ffff);
        reg_addr = 2'd1;
        #1;
        check({tag, " R6 zero write keeps event"}, 64'(reg_rdata), 64'h0080_0000);
        wr(2'd1, 32'h0080_0000);
        reg_addr = 2'd1;
        #1;
        check({tag, " R6 clear by one"}, 64'(reg_rdata), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi;
        logic [31:0] c;
        logic [31:0] c2;
        int spd;
        void'($urandom(32'd913));
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1357 ^ (16'(i) * 16'h0a3d);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            check("R1 register reset value", 64'(reg_rdata), 64'd0);
        end
        check("R1 MDC and MDIO at reset", {61'd0, mdc, mdio_oe, mdio_o}, 64'd0);

        wr(2'd2, 32'd1);
        reg_addr = 2'd2;
        #1;
        check("R3 speed readback", 64'(reg_rdata), 64'd1);

        // directed write then read-back of the same PHY register
        c = mk_cmd(2'b01, 5'd1, 5'd5, 16'hbeef);
        begin_frame(c);
        end_frame(c, 1, "directed write");
        wr(2'd2, 32'd3);
        c = mk_cmd(2'b10, 5'd1, 5'd5, 16'h0000);
        begin_frame(c);
        end_frame(c, 3, "directed read");

        // R7 read data with alternating bits
        phy_mem[9] = 16'ha55a;
        wr(2'd2, 32'd2);
        c = mk_cmd(2'b10, 5'd31, 5'd9, 16'hffff);
        begin_frame(c);
        end_frame(c, 2, "R7 pattern read");

        // constrained random frames
        for (int n = 0; n < 16; n++) begin
            spd = $urandom_range(1, 4);
            wr(2'd2, 32'(spd));
            c = mk_cmd(($urandom % 2) ? 2'b10 : 2'b01, 5'($urandom), 5'($urandom),
                       16'($urandom));
            begin_frame(c);
            end_frame(c, spd, "random frame");
        end

        // R8 command write during a frame is ignored
        wr(2'd2, 32'd2);
        c = mk_cmd(2'b01, 5'd3, 5'd12, 16'h3c3c);
        c2 = mk_cmd(2'b10, 5'd7, 5'd1, 16'h0000);
        begin_frame(c);
        repeat (30) @(negedge clk);
        wr(2'd0, c2);
        end_frame(c, 2, "R8 write ignored mid frame");
        c = mk_cmd(2'b10, 5'd3, 5'd12, 16'h0000);
        begin_frame(c);
        repeat (200) @(negedge clk);
        wr(2'd0, 32'h5ac3_0f0f);
        end_frame(c, 2, "R8 read with late write");

        // R4 speed zero holds the frame
        wr(2'd2, 32'd0);
        c = mk_cmd(2'b01, 5'd2, 5'd20, 16'h0f0f);
        begin_frame(c);
        reg_addr = 2'd1;
        hi = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (mdc || reg_rdata[23]) hi++;
        end
        check("R4 MDC frozen at speed zero", 64'(hi), 64'd0);
        check("R4 no pulses at speed zero", 64'(rcnt), 64'd0);
        wr(2'd2, 32'd2);
        end_frame(c, 0, "R4 resumed frame");

        // boundary: largest speed value
        wr(2'd2, 32'd255);
        c = mk_cmd(2'b10, 5'd0, 5'd31, 16'h0000);
        begin_frame(c);
        end_frame(c, 255, "R3 max speed read");

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

endmodule